// File: doc/BRIEF.md
# Link bring-up speed sequencer

This block brings a serial link up in two steps. A start pulse makes it program a maximum-speed field of 1 (first generation) into a local link-capability register. It then enables training and polls the link-up input until the link trains. Only after the link is up does it raise the field to 2 (second generation). It then sets a directed-speed-change request bit in a local speed-control register and waits for the link partner to clear that bit. Finally it polls link-up once more. Starting at first-generation speed gives the first training the best chance of finding the partner. Second generation is unlocked only after that first training has succeeded.

Every wait is a bounded poll loop. The loop samples its condition at most `POLL_LIMIT` times, with `POLL_GAP` clock cycles between samples. When any loop runs out of polls, the sequence ends in failure. On success the negotiated generation is taken from the link status word. A one-cycle done pulse ends every attempt. The pass/fail flag and the generation hold their values until the next start. The training state machine and the link partner sit outside the block. Through `chg_clr_i`, the partner clears the speed-change bit once it has finished the change.

Top module: `lnk_speed_seq`

## Requirements
- R1: After reset, `train_en_o`, `done_o`, `pass_o` and `gen_o` are 0, `cap_reg_o` equals `CAP_INIT` and `spd_ctl_o` equals `CTL_INIT`.
- R2: After a start, `cap_reg_o[3:0]` (the maximum-speed field) reads 1 by the time `train_en_o` rises. Bits 31:4 of `cap_reg_o` always keep their `CAP_INIT` value.
- R3: A start accepted in idle drives `train_en_o` to 0 in the next cycle. It returns to 1 two cycles after the start was sampled and stays 1 until the next accepted start.
- R4: The link-up input is sampled at most `POLL_LIMIT` times per wait, once every `POLL_GAP` cycles, with the first sample in the first cycle of the wait. If the first link-up wait never sees the link up, `done_o` rises with `pass_o`=0 exactly 1+(`POLL_LIMIT`-1)*`POLL_GAP` cycles after `train_en_o` rises. Link-up that first appears at the last sample still counts as success.
- R5: Once the first wait succeeds, `cap_reg_o[3:0]` is rewritten to 2 before the speed-change request is issued.
- R6: The speed-change request is bit 17 of `spd_ctl_o`. The block sets it after the field reads 2, and all other bits of `spd_ctl_o` keep their `CTL_INIT` value.
- R7: A one-cycle `chg_clr_i` pulse clears bit 17. The change counts as finished when the block samples bit 17 as 0. If bit 17 stays set for `POLL_LIMIT` samples, the attempt fails.
- R8: After the change finishes, link-up is waited for again under the same limit. Failure of that wait ends the attempt with `pass_o`=0.
- R9: On success `gen_o` equals bits 19:16 of `link_stat_i` at the final successful sample. On failure `gen_o` is 0.
- R10: `done_o` is high for exactly one cycle per attempt. `pass_o` and `gen_o` hold from the done cycle until the next accepted start, which clears them to 0.
- R11: A start pulse while a sequence is running is ignored. It causes no extra done, leaves `train_en_o` high and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a bring-up attempt when idle |
| link_up_i | input | 1 | Link trained indication from the training logic |
| link_stat_i | input | 32 | Link status word; bits 19:16 carry the current generation |
| chg_clr_i | input | 1 | Partner pulse that clears the speed-change request bit |
| train_en_o | output | 1 | Training enable |
| cap_reg_o | output | 32 | Link-capability register; bits 3:0 are the maximum-speed field |
| spd_ctl_o | output | 32 | Speed-control register; bit 17 is the directed-change request |
| done_o | output | 1 | One-cycle end-of-attempt pulse |
| pass_o | output | 1 | Attempt result, 1 on success |
| gen_o | output | 4 | Negotiated generation on success, else 0 |

## Verification
The hardest cases to reach from the ports are those right at the edge of a poll budget. One is a link that comes up exactly at the final permitted sample. Another is one that comes up a single cycle too late. Both require exact knowledge of when each sample is taken. The bench drives a partner model whose delays are counted from the rise of `train_en_o`, with a short `POLL_GAP`. It places link-up on the last sample cycle and one cycle after it. A speed change that never completes, and a second training that never finishes, are reached by having the partner withhold the clear pulse or the second link-up.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int REG_W   = 32;
  localparam int SPD_W   = 4;
  localparam int CHG_BIT = 17;
  localparam int GEN_LSB = 16;
  localparam int GEN_W   = 4;

  localparam logic [SPD_W-1:0] SPD_GEN1 = 4'd1;
  localparam logic [SPD_W-1:0] SPD_GEN2 = 4'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CAP1,
    S_TRAIN,
    S_WUP1,
    S_CAP2,
    S_REQ,
    S_WCHG,
    S_WUP2
  } seq_st_t;
endpackage

// File: rtl/lbs_regs.sv
module lbs_regs
  import lbs_pkg::*;
#(
  parameter logic [REG_W-1:0] CAP_INIT = '0,
  parameter logic [REG_W-1:0] CTL_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd_we,
  input  logic [SPD_W-1:0] spd_val,
  input  logic             chg_set,
  input  logic             chg_clr,
  output logic [REG_W-1:0] cap_q,
  output logic [REG_W-1:0] ctl_q
);
  localparam logic [REG_W-1:0] CHG_MASK = REG_W'(1) << CHG_BIT;

  logic [REG_W-1:0] cap_d, ctl_d;
  logic             cap_en, ctl_en;

  // read-modify-write: only the addressed field changes
  always_comb begin
    cap_d  = cap_q;
    cap_en = spd_we;
    if (spd_we) cap_d[SPD_W-1:0] = spd_val;
  end

  always_comb begin
    ctl_d  = ctl_q;
    ctl_en = chg_set | chg_clr;
    if (chg_set)      ctl_d[CHG_BIT] = 1'b1;
    else if (chg_clr) ctl_d[CHG_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= CAP_INIT;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_INIT;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  p_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q[REG_W-1:SPD_W] == CAP_INIT[REG_W-1:SPD_W]);

  p_ctl_others_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~CHG_MASK) == (CTL_INIT & ~CHG_MASK));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_set |=> ctl_q[CHG_BIT]);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_clr && !chg_set) |=> !ctl_q[CHG_BIT]);
endmodule

// File: rtl/lbs_poll.sv
module lbs_poll #(
  parameter int LIMIT = 200,
  parameter int GAP   = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  output logic poll,
  output logic last
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;

  logic [TW-1:0] tries_q, tries_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          cnt_en;

  assign poll = active && (gap_q == '0);
  assign last = (tries_q == TW'(LIMIT - 1));

  always_comb begin
    tries_d = tries_q;
    gap_d   = gap_q;
    cnt_en  = arm | active;
    if (arm) begin
      tries_d = '0;
      gap_d   = '0;
    end else if (active) begin
      if (gap_q == '0) begin
        gap_d = GW'(GAP - 1);
        if (!last) tries_d = tries_q + 1'b1;
      end else begin
        gap_d = gap_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
      gap_q   <= '0;
    end else if (cnt_en) begin
      tries_q <= tries_d;
      gap_q   <= gap_d;
    end
  end

  p_tries_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TW'(LIMIT - 1));

  generate
    if (GAP > 1) begin : g_gap_chk
      p_poll_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && !arm) |=> !poll);
    end
  endgenerate
endmodule

// File: rtl/lnk_speed_seq.sv
module lnk_speed_seq
  import lbs_pkg::*;
#(
  parameter int               POLL_LIMIT = 200,
  parameter int               POLL_GAP   = 10000,
  parameter logic [REG_W-1:0] CAP_INIT   = 32'h0000_0012,
  parameter logic [REG_W-1:0] CTL_INIT   = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             link_up_i,
  input  logic [31:0]      link_stat_i,
  input  logic             chg_clr_i,
  output logic             train_en_o,
  output logic [31:0]      cap_reg_o,
  output logic [31:0]      spd_ctl_o,
  output logic             done_o,
  output logic             pass_o,
  output logic [3:0]       gen_o
);
  seq_st_t          st_q, st_d;
  logic             spd_we, chg_set;
  logic [SPD_W-1:0] spd_val;
  logic             poll, last, arm, active, wait_d;
  logic             ok_ev, fail_ev, go;
  logic             train_q, train_d, train_en;
  logic             done_q, pass_q, pass_d, res_en;
  logic [GEN_W-1:0] gen_q, gen_d;

  lbs_regs #(.CAP_INIT(CAP_INIT), .CTL_INIT(CTL_INIT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .spd_we  (spd_we),
    .spd_val (spd_val),
    .chg_set (chg_set),
    .chg_clr (chg_clr_i),
    .cap_q   (cap_reg_o),
    .ctl_q   (spd_ctl_o)
  );

  lbs_poll #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .active (active),
    .poll   (poll),
    .last   (last)
  );

  // sequencing
  always_comb begin
    st_d    = st_q;
    spd_we  = 1'b0;
    spd_val = SPD_GEN1;
    chg_set = 1'b0;
    ok_ev   = 1'b0;
    fail_ev = 1'b0;
    go      = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        go   = 1'b1;
        st_d = S_CAP1;
      end
      S_CAP1: begin
        spd_we  = 1'b1;
        spd_val = SPD_GEN1;
        st_d    = S_TRAIN;
      end
      S_TRAIN: st_d = S_WUP1;
      S_WUP1: if (poll) begin
        if (link_up_i) st_d = S_CAP2;
        else if (last) begin
          st_d    = S_IDLE;
          fail_ev = 1'b1;
        end
      end
      S_CAP2: begin
        spd_we  = 1'b1;
        spd_val = SPD_GEN2;
        st_d    = S_REQ;
      end
      S_REQ: begin
        chg_set = 1'b1;
        st_d    = S_WCHG;
      end
      S_WCHG: if (poll) begin
        if (!spd_ctl_o[CHG_BIT]) st_d = S_WUP2;
        else if (last) begin
          st_d    = S_IDLE;
          fail_ev = 1'b1;
        end
      end
      S_WUP2: if (poll) begin
        if (link_up_i) begin
          st_d  = S_IDLE;
          ok_ev = 1'b1;
        end else if (last) begin
          st_d    = S_IDLE;
          fail_ev = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign active = (st_q == S_WUP1) || (st_q == S_WCHG) || (st_q == S_WUP2);
  assign wait_d = (st_d == S_WUP1) || (st_d == S_WCHG) || (st_d == S_WUP2);
  assign arm    = wait_d && (st_d != st_q);

  // training enable and result registers
  always_comb begin
    train_en = go | (st_q == S_TRAIN);
    train_d  = (st_q == S_TRAIN);
    res_en   = go | ok_ev | fail_ev;
    pass_d   = ok_ev;
    gen_d    = ok_ev ? link_stat_i[GEN_LSB +: GEN_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        train_q <= 1'b0;
    else if (train_en) train_q <= train_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= ok_ev | fail_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      gen_q  <= '0;
    end else if (res_en) begin
      pass_q <= pass_d;
      gen_q  <= gen_d;
    end
  end

  assign train_en_o = train_q;
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign gen_o      = gen_q;

  p_gen1_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WUP1) |-> (cap_reg_o[SPD_W-1:0] == SPD_GEN1));

  p_gen2_before_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_REQ || st_q == S_WCHG || st_q == S_WUP2) |-> (cap_reg_o[SPD_W-1:0] == SPD_GEN2));

  p_req_after_gen2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spd_ctl_o[CHG_BIT]) |-> (cap_reg_o[SPD_W-1:0] == SPD_GEN2));

  p_train_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> train_q);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !start_i) |=> ($stable(pass_q) && $stable(gen_q)));

  p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> (!pass_q && gen_q == '0));

  p_gen_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ev |=> (gen_q == $past(link_stat_i[GEN_LSB +: GEN_W])));
endmodule

// File: tb/lnk_speed_seq_bench.sv
module lnk_speed_seq_bench;
  localparam int          LIM  = 200;
  localparam int          GAP  = 4;
  localparam logic [31:0] CAPI = 32'hA5C3_0F0E;
  localparam logic [31:0] CTLI = 32'h0001_2345;
  localparam int          FAIL_DLY = 1 + (LIM - 1) * GAP;

  logic        clk, rst_n, start_i, link_up_i, chg_clr_i;
  logic [31:0] link_stat_i;
  logic        train_en_o, done_o, pass_o;
  logic [31:0] cap_reg_o, spd_ctl_o;
  logic [3:0]  gen_o;

  lnk_speed_seq #(.POLL_LIMIT(LIM), .POLL_GAP(GAP), .CAP_INIT(CAPI), .CTL_INIT(CTLI)) u_lnk_speed_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_up_i(link_up_i),
    .link_stat_i(link_stat_i), .chg_clr_i(chg_clr_i), .train_en_o(train_en_o),
    .cap_reg_o(cap_reg_o), .spd_ctl_o(spd_ctl_o), .done_o(done_o),
    .pass_o(pass_o), .gen_o(gen_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit pass; logic [3:0] gen; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // partner model knobs (-1 = never)
  int up1, lat, up2;

  initial begin
    int ph;
    int cnt;
    ph = 0; cnt = 0;
    link_up_i = 1'b0; chg_clr_i = 1'b0;
    forever begin
      @(negedge clk);
      chg_clr_i = 1'b0;
      if (!train_en_o) begin
        ph = 0; cnt = 0; link_up_i = 1'b0;
      end else begin
        case (ph)
          0: if (up1 >= 0 && cnt >= up1) begin link_up_i = 1'b1; ph = 1; cnt = 0; end else cnt++;
          1: if (spd_ctl_o[17]) begin link_up_i = 1'b0; ph = 2; cnt = 0; end
          2: if (lat >= 0 && cnt >= lat) begin chg_clr_i = 1'b1; ph = 3; cnt = 0; end else cnt++;
          3: if (up2 >= 0 && cnt >= up2) begin link_up_i = 1'b1; ph = 4; end else cnt++;
          default: ;
        endcase
      end
    end
  end

  // monitor: scoreboard compare and request-bit ordering
  logic prev17 = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R11", "done with nothing expected", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(pass_o == e.pass, "R9", "pass flag at done", pass_o, e.pass);
          chk(gen_o == e.gen, "R9", "generation at done", gen_o, e.gen);
        end
      end
      if (spd_ctl_o[17] && !prev17) begin
        chk(cap_reg_o[3:0] == 4'd2, "R5", "speed field when request set", cap_reg_o[3:0], 2);
        chk((spd_ctl_o & ~32'h0002_0000) == (CTLI & ~32'h0002_0000), "R6",
            "other speed-control bits", spd_ctl_o, CTLI);
      end
      prev17 <= spd_ctl_o[17];
    end
  end

  task automatic run_case(input int u1, input int l, input int u2, input logic [3:0] g,
                          input bit ep, input logic [3:0] eg, input bit mid, input int fdly,
                          input string tag);
    int t_tr;
    up1 = u1; lat = l; up2 = u2;
    link_stat_i = {12'hABC, g, 16'h5A5A};
    exp_q.push_back('{ep, eg});
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(train_en_o == 1'b0, "R3", {tag, " training enable dropped on start"}, train_en_o, 0);
    chk(pass_o == 1'b0 && gen_o == 4'd0, "R10", {tag, " result cleared by start"}, gen_o, 0);
    while (!train_en_o) @(negedge clk);
    t_tr = cyc;
    chk(cap_reg_o[3:0] == 4'd1, "R2", {tag, " gen1 field at training start"}, cap_reg_o[3:0], 1);
    chk(cap_reg_o[31:4] == CAPI[31:4], "R2", {tag, " upper capability bits"}, cap_reg_o[31:4], CAPI[31:4]);
    if (mid) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      @(negedge clk);
      chk(train_en_o == 1'b1, "R11", {tag, " busy start leaves training on"}, train_en_o, 1);
    end
    while (!done_o) @(negedge clk);
    if (fdly >= 0)
      chk(cyc - t_tr == fdly, "R4", {tag, " cycles to failure"}, cyc - t_tr, fdly);
    if (ep) begin
      chk(cap_reg_o[3:0] == 4'd2, "R5", {tag, " gen2 field after pass"}, cap_reg_o[3:0], 2);
      chk(spd_ctl_o == CTLI, "R7", {tag, " request bit cleared"}, spd_ctl_o, CTLI);
    end
    chk(train_en_o == 1'b1, "R3", {tag, " training held at done"}, train_en_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R10", {tag, " done lasts one cycle"}, done_o, 0);
    chk(pass_o == ep && gen_o == eg, "R10", {tag, " result held"}, gen_o, eg);
    repeat (6) @(negedge clk);
    chk(pass_o == ep && gen_o == eg, "R10", {tag, " result still held"}, gen_o, eg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; link_stat_i = '0;
    up1 = -1; lat = -1; up2 = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(train_en_o == 0 && done_o == 0, "R1", "reset enable and done", train_en_o, 0);
    chk(pass_o == 0 && gen_o == 0, "R1", "reset result", gen_o, 0);
    chk(cap_reg_o == CAPI, "R1", "reset capability register", cap_reg_o, CAPI);
    chk(spd_ctl_o == CTLI, "R1", "reset speed-control register", spd_ctl_o, CTLI);

    run_case(10, 6, 8, 4'd2, 1'b1, 4'd2, 1'b0, -1, "pass gen2");
    run_case(0, 0, 0, 4'd1, 1'b1, 4'd1, 1'b0, -1, "pass gen1 fast partner");
    run_case(-1, 0, 0, 4'd2, 1'b0, 4'd0, 1'b0, FAIL_DLY, "R4 no link");
    run_case((LIM - 1) * GAP, 3, 3, 4'd2, 1'b1, 4'd2, 1'b0, -1, "R4 up at last poll");
    run_case((LIM - 1) * GAP + 1, 3, 3, 4'd2, 1'b0, 4'd0, 1'b0, FAIL_DLY, "R4 up one cycle late");
    run_case(30, 5, 5, 4'd5, 1'b1, 4'd5, 1'b1, -1, "R11 busy start");
    run_case(4, 4, -1, 4'd2, 1'b0, 4'd0, 1'b0, -1, "R8 second wait fails");
    run_case(4, -1, 0, 4'd2, 1'b0, 4'd0, 1'b0, -1, "R7 change never clears");

    chk(exp_q.size() == 0, "R11", "all expected results consumed", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule